// File: doc/BRIEF.md
# Retired-Instruction Periodic Interrupt Tick

This block produces a periodic interrupt event whose period is counted in retired processor instructions, not in clock cycles. A CPU core provides a one-cycle strobe for each instruction it completes. A fixed prescaler divides those strobes by 20. A period counter then counts the prescaler ticks against a period value N, which the host or debug side supplies on a configuration port. The software running on the processor has no path to N.

After N×20 retirements the block raises a single-cycle fire pulse. That pulse is meant to set a timer interrupt flag in a separate peripheral-style flag and enable unit. The counter then starts the next period with no gap. Because every step is driven by retirements, a slow or stalled core stretches the period in exact proportion. While nothing retires, no period time passes.

The period value is captured when the first prescaler tick of each period occurs. A change to N therefore applies from the next period onward. A captured value of zero suppresses fire pulses until a nonzero value is captured at a later prescaler tick.

Top module: `itick_gen`

## Requirements
- R1: A synchronous active-low reset clears the prescaler, the period counter and `fire_o`. After reset, including a reset in the middle of a period, the first pulse needs a full N×20 retirements.
- R2: With N ≥ 1 captured, `fire_o` is high in the clock cycle after the edge that samples the (N×20)-th retirement strobe of the period, counted from the period's start. It is low after every other retirement.
- R3: `fire_o` lasts exactly one cycle. The next period starts immediately, so later pulses follow after exactly N×20 further retirements with none lost.
- R4: If `period_cfg_i` is 0 at the first prescaler tick of a period, no pulse is generated, however many instructions retire. Once a nonzero value is present at a later prescaler tick, generation resumes from that tick.
- R5: Cycles without a retirement strobe do not advance either counter. `fire_o` is only high in a cycle that directly follows a sampled retirement.
- R6: `period_cfg_i` is sampled at the edge of the period's first prescaler tick (its 20th retirement). Changes after that point affect only the following period.
- R7: N is 16 bits wide, and large values such as N = 1200 give a period of exactly 24,000 retirements.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| retire_i | input | 1 | One-cycle strobe per retired instruction |
| period_cfg_i | input | 16 | Period N, in units of 20 retirements (host side) |
| fire_o | output | 1 | Single-cycle period-expiry event |

## Verification
A wrong prescaler phase shifts every pulse by up to 19 retirements. A wrong remaining count moves each pulse by a multiple of 20. Both errors show up at the very first expiry after reset, which is at most N×20 retirements in.

A counter that advanced on idle cycles would fire inside a stall window, or in a cycle not preceded by a retirement. Wrong handling of a reloaded or captured value shows up one period later, as a pulse at the old length or as a missing pulse after the value drops to zero.

// File: rtl/itick_pkg.sv
// Package: shared constants for the retired-instruction tick generator.
// Assumes: a single clock domain; the divide ratio is a compile-time constant.
package itick_pkg;
    localparam int unsigned ITICK_DIV   = 20;   // retirements per prescaler tick
    localparam int unsigned ITICK_CFG_W = 16;   // width of the period value
endpackage

// File: rtl/itick_prescale.sv
// Module: itick_prescale
// Divides the retirement strobe by DIV. It emits a combinational tick in the
// same cycle as the DIV-th strobe and wraps to zero at that strobe.
// Assumes: DIV >= 2; step_i is a one-cycle-per-event strobe.
module itick_prescale #(
    parameter int unsigned DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic tick_o
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] phase_q;
    logic          at_last;

    // Purpose: flag the final phase and qualify it with a strobe.
    always_comb begin
        at_last = (phase_q == LAST);
        tick_o  = step_i && at_last;
    end

    // Purpose: advance the phase on each strobe, wrapping after DIV strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (step_i) phase_q <= at_last ? '0 : phase_q + 1'b1;
    end

    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= LAST);                                    // R2
    AST_PHASE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i |=> $stable(phase_q));                       // R5
endmodule

// File: rtl/itick_period.sv
// Module: itick_period
// Counts prescaler ticks down from a captured period value and registers a
// one-cycle fire on the tick that ends the period. A remaining count of zero
// means "start of period": the next tick then uses cfg_i directly, so the new
// period starts at once with no lost tick. A zero cfg_i leaves the counter idle.
// Assumes: tick_i is a single-cycle strobe.
module itick_period #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [CW-1:0] cfg_i,
    output logic          fire_o
);
    logic [CW-1:0] left_q;
    logic [CW-1:0] live;
    logic          ends_now;

    // Purpose: pick the count in effect and detect the final tick.
    always_comb begin
        live     = (left_q == '0) ? cfg_i : left_q;
        ends_now = tick_i && (live == CW'(1));
    end

    // Purpose: step the remaining count and register the fire event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
            fire_o <= 1'b0;
        end else begin
            fire_o <= ends_now;
            if (tick_i) left_q <= (live == '0) ? '0 : live - 1'b1;
        end
    end

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && left_q == '0 && cfg_i == '0) |=> !fire_o); // R4
    AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(left_q));                         // R5
endmodule

// File: rtl/itick_gen.sv
// Module: itick_gen (top)
// Periodic interrupt event counted in retired instructions: a fixed divide-by-DIV
// prescaler feeds a period counter that fires every N prescaler ticks.
// Assumes: retire_i pulses once per retired instruction; period_cfg_i comes from
// the host side and may change at any time.
module itick_gen #(
    parameter int unsigned DIV = itick_pkg::ITICK_DIV,
    parameter int unsigned CW  = itick_pkg::ITICK_CFG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          retire_i,
    input  logic [CW-1:0] period_cfg_i,
    output logic          fire_o
);
    logic pre_tick;

    itick_prescale #(.DIV(DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (retire_i),
        .tick_o (pre_tick)
    );

    itick_period #(.CW(CW)) u_per (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (pre_tick),
        .cfg_i  (period_cfg_i),
        .fire_o (fire_o)
    );

    AST_FIRE_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |-> $past(retire_i));                          // R5
    AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> !fire_o);                                  // R3
endmodule

// File: tb/itick_gen_bench.sv
module itick_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        retire_i = 1'b0;
    logic [15:0] period_cfg_i = 16'd0;
    logic        fire_o;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    itick_gen u_itick_gen (
        .clk          (clk),
        .rst_n        (rst_n),
        .retire_i     (retire_i),
        .period_cfg_i (period_cfg_i),
        .fire_o       (fire_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: fire_o=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // one retirement, then `gap` idle cycles; fire_o is checked after the retire
    // edge and is expected low during every idle cycle
    task automatic retire(input logic exp, input int gap, input string tag);
        @(negedge clk) retire_i = 1'b1;
        @(negedge clk) retire_i = 1'b0;
        check(fire_o, exp, tag);
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            check(fire_o, 1'b0, tag);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    // a full period of n*20 retirements, pulse only on the last
    task automatic period(input int n, input string tag);
        for (int i = 1; i <= n * 20; i++)
            retire(i == n * 20, i % 3, tag);
    endtask

    initial begin
        // R1: reset state
        period_cfg_i = 16'd3;
        do_reset();
        check(fire_o, 1'b0, "R1 reset");

        // R2 R3: sweep of small N, three back-to-back periods each
        for (int n = 1; n <= 8; n++) begin
            period_cfg_i = 16'(n);
            do_reset();
            period(n, "R2 first period");
            period(n, "R3 second period");
            period(n, "R3 third period");
        end

        // R5: a long stall one retirement short of expiry
        period_cfg_i = 16'd2;
        do_reset();
        for (int i = 1; i < 40; i++) retire(1'b0, 0, "R5 pre-stall");
        for (int c = 0; c < 300; c++) begin
            @(negedge clk);
            check(fire_o, 1'b0, "R5 stall");
        end
        retire(1'b1, 2, "R5 after stall");

        // R6: change N mid-period (after its first tick); only the next period sees it
        for (int i = 1; i <= 30; i++) retire(1'b0, 1, "R6 before change");
        period_cfg_i = 16'd4;
        for (int i = 31; i <= 40; i++) retire(i == 40, 0, "R6 current period");
        period(4, "R6 next period");

        // R4: zero disables, nonzero resumes
        period_cfg_i = 16'd0;
        for (int i = 1; i <= 200; i++) retire(1'b0, i % 2, "R4 zero");
        period_cfg_i = 16'd2;
        period(2, "R4 resumed");

        // R1: reset in the middle of a period
        for (int i = 1; i <= 25; i++) retire(1'b0, 0, "R1 pre-reset");
        do_reset();
        period(2, "R1 after mid reset");

        // R7: large N
        period_cfg_i = 16'd1200;
        do_reset();
        period(1200, "R7 N=1200");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule